// File: doc/BRIEF.md
# Shared-Datapath Five-Function ALU

A purely combinational 32-bit arithmetic unit. A 3-bit function code picks one of five operations: sum, difference, increment, decrement and unsigned product. The unit is built from three reusable arithmetic blocks: a full-width adder, a full-width subtractor and a half-width multiplier. Only the adder and the subtractor do arithmetic on the full operand width.

Increment and decrement have no hardware of their own. A small operand multiplexer sits outside the arithmetic blocks. It replaces the second operand with the constant one when the low function bit is set. A three-way result selector, steered by the two upper function bits, then chooses which unit drives the output.

The multiplier reads only the lower half of each operand as unsigned numbers and returns the full double-width product. All results wrap at the datapath width, and no carry, borrow or flag leaves the block.

Top module: `shared_alu`

## Requirements
- R1: With func_i = 3'b000, res_o equals (a_i + b_i) mod 2^32.
- R2: With func_i = 3'b001, res_o equals (a_i + 1) mod 2^32, and b_i has no effect on res_o.
- R3: With func_i = 3'b010, res_o equals (a_i - b_i) mod 2^32.
- R4: With func_i = 3'b011, res_o equals (a_i - 1) mod 2^32, and b_i has no effect on res_o.
- R5: With func_i[2] = 1, res_o is the multiplier result for all four values of func_i[1:0] (codes 3'b100 to 3'b111).
- R6: The multiplier uses only a_i[15:0] and b_i[15:0], taken as unsigned values; bits [31:16] of both operands have no effect on the product.
- R7: The product is the full 32-bit unsigned value, so 16'hFFFF times 16'hFFFF gives 32'hFFFE_0001.
- R8: res_o is a purely combinational function of the inputs. It follows any input change with no clock edge, and it is defined for every function code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| func_i | input | 3 | Function code |
| res_o | output | 32 | Selected result |

## Verification
The hardest cases to separate at the ports are the two reused paths. A fault in the operand multiplexer could feed b_i into increment or decrement, and it would pass unnoticed whenever b_i happens to equal one. The bench therefore drives a_i fixed and sweeps b_i through zero, one, all ones and a large value. It expects an unchanged result each time.

For the multiply codes, the upper halves of both operands are loaded with nonzero patterns. This exposes any leak of those bits into the product. All four multiply codes are then compared against one another.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    SEL_ADD = 2'b00,
    SEL_SUB = 2'b01,
    SEL_MUL = 2'b10
  } res_sel_e;

  // upper two function bits -> result source
  function automatic res_sel_e decode_sel(input logic [2:0] func);
    if (func[2])      return SEL_MUL;
    else if (func[1]) return SEL_SUB;
    else              return SEL_ADD;
  endfunction
endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  output logic [WIDTH-1:0] sum_o
);
  always_comb begin
    sum_o = x_i + y_i;
    if (!$isunknown({x_i, y_i}))
      a_r1_add_inverse: assert (sum_o - y_i == x_i)
        else $error("adder result not invertible");
  end
endmodule

// File: rtl/alu_subtractor.sv
module alu_subtractor #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  output logic [WIDTH-1:0] diff_o
);
  always_comb begin
    diff_o = x_i - y_i;
    if (!$isunknown({x_i, y_i}))
      a_r3_sub_inverse: assert (diff_o + y_i == x_i)
        else $error("subtractor result not invertible");
  end
endmodule

// File: rtl/alu_mult.sv
module alu_mult #(
  parameter int unsigned IN_W = 16
) (
  input  logic [IN_W-1:0]   x_i,
  input  logic [IN_W-1:0]   y_i,
  output logic [2*IN_W-1:0] prod_o
);
  always_comb begin
    prod_o = {{IN_W{1'b0}}, x_i} * {{IN_W{1'b0}}, y_i};
    if (!$isunknown({x_i, y_i})) begin
      a_r7_zero_factor: assert (!((x_i == '0) || (y_i == '0)) || prod_o == '0)
        else $error("product nonzero with zero factor");
      a_r7_parity: assert (prod_o[0] == (x_i[0] & y_i[0]))
        else $error("product lsb wrong");
    end
  end
endmodule

// File: rtl/alu_operand_mux.sv
module alu_operand_mux #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             force_one_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] opnd_o
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};
  always_comb begin
    opnd_o = force_one_i ? ONE : b_i;
    if (!$isunknown(force_one_i))
      a_r2_r4_const_one: assert (!force_one_i || opnd_o == ONE)
        else $error("constant operand not one");
  end
endmodule

// File: rtl/shared_alu.sv
module shared_alu #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [2:0]       func_i,
  output logic [WIDTH-1:0] res_o
);
  import alu_pkg::*;

  localparam int unsigned MUL_W = WIDTH / 2;

  logic [WIDTH-1:0] opnd_b;
  logic [WIDTH-1:0] add_res;
  logic [WIDTH-1:0] sub_res;
  logic [WIDTH-1:0] mul_res;
  res_sel_e         sel;

  // increment/decrement reuse the adder/subtractor via this mux
  alu_operand_mux #(.WIDTH(WIDTH)) u_opnd (
    .force_one_i (func_i[0]),
    .b_i         (b_i),
    .opnd_o      (opnd_b)
  );

  alu_adder #(.WIDTH(WIDTH)) u_add (
    .x_i   (a_i),
    .y_i   (opnd_b),
    .sum_o (add_res)
  );

  alu_subtractor #(.WIDTH(WIDTH)) u_sub (
    .x_i    (a_i),
    .y_i    (opnd_b),
    .diff_o (sub_res)
  );

  alu_mult #(.IN_W(MUL_W)) u_mul (
    .x_i    (a_i[MUL_W-1:0]),
    .y_i    (b_i[MUL_W-1:0]),
    .prod_o (mul_res)
  );

  assign sel = decode_sel(func_i);

  always_comb begin
    unique case (sel)
      SEL_ADD: res_o = add_res;
      SEL_SUB: res_o = sub_res;
      default: res_o = mul_res;
    endcase
    if (!$isunknown({a_i, b_i, func_i})) begin
      a_r8_defined: assert (!$isunknown(res_o))
        else $error("result undefined");
      a_r5_mul_code: assert (!func_i[2] || sel == SEL_MUL)
        else $error("multiply code not routed to multiplier");
      a_r6_mul_fits: assert (!func_i[2] || (res_o == '0) == ((a_i[MUL_W-1:0] == '0) || (b_i[MUL_W-1:0] == '0)))
        else $error("product zero mismatch");
    end
  end
endmodule

// File: tb/shared_alu_test.sv
module shared_alu_test;
  logic        clk = 1'b0;
  logic [31:0] a, b;
  logic [2:0]  f;
  logic [31:0] res;
  int          n_chk = 0;
  int          n_bad = 0;
  int          cyc = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  shared_alu uut (.a_i(a), .b_i(b), .func_i(f), .res_o(res));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] av, input logic [31:0] bv, input logic [2:0] fv);
    @(negedge clk);
    a = av; b = bv; f = fv;
    #1;
  endtask

  task automatic t_idle;
    apply(32'h0, 32'h0, 3'b000);
    check("R1 idle zero", res, 32'h0);
  endtask

  task automatic t_add;
    apply(32'h1234_5678, 32'h1111_1111, 3'b000);
    check("R1 add", res, 32'h2345_6789);
    apply(32'hFFFF_FFFF, 32'h0000_0002, 3'b000);
    check("R1 add wrap", res, 32'h0000_0001);
  endtask

  task automatic t_inc;
    logic [31:0] bs [4] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000};
    foreach (bs[i]) begin
      apply(32'h0000_00FF, bs[i], 3'b001);
      check("R2 inc ignores b", res, 32'h0000_0100);
    end
    apply(32'hFFFF_FFFF, 32'h5, 3'b001);
    check("R2 inc wrap", res, 32'h0);
  endtask

  task automatic t_sub;
    apply(32'h0000_1000, 32'h0000_0001, 3'b010);
    check("R3 sub", res, 32'h0000_0FFF);
    apply(32'h0000_0003, 32'h0000_0005, 3'b010);
    check("R3 sub wrap", res, 32'hFFFF_FFFE);
  endtask

  task automatic t_dec;
    logic [31:0] bs [4] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7654_3210};
    foreach (bs[i]) begin
      apply(32'h0000_0100, bs[i], 3'b011);
      check("R4 dec ignores b", res, 32'h0000_00FF);
    end
    apply(32'h0, 32'h9, 3'b011);
    check("R4 dec wrap", res, 32'hFFFF_FFFF);
  endtask

  task automatic t_mul;
    for (int c = 4; c < 8; c++) begin
      apply(32'hABCD_0123, 32'h5A5A_0010, 3'(c));
      check("R5 R6 mul code", res, 32'h0000_1230);
    end
    apply(32'hFFFF_0000, 32'hFFFF_1234, 3'b100);
    check("R6 upper bits ignored", res, 32'h0);
    apply(32'h0000_FFFF, 32'h0000_FFFF, 3'b111);
    check("R7 full product", res, 32'hFFFE_0001);
  endtask

  task automatic t_comb;
    @(negedge clk);
    a = 32'd10; b = 32'd3; f = 3'b000;
    #0.5 check("R8 comb add", res, 32'd13);
    f = 3'b010;
    #0.5 check("R8 comb sub", res, 32'd7);
    b = 32'd4;
    #0.5 check("R8 comb b change", res, 32'd6);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 10000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got %0d cycles expected < 10000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    a = '0; b = '0; f = '0;
    t_idle();
    t_add();
    t_inc();
    t_sub();
    t_dec();
    t_mul();
    t_comb();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule